// File: doc/BRIEF.md
# Safeload Parameter Transfer Unit

This block lets a host replace a small group of signal-processing coefficients in parameter RAM as one update while the DSP core keeps running. The host fills up to five staging entries. Each entry holds a 28-bit parameter word and a 10-bit RAM target. The host then raises a commit request. The request is held until the next audio frame boundary. After that boundary the unit moves the staged entries into parameter RAM, one per clock cycle in which the core leaves the RAM free. A whole set, such as the five coefficients of one biquad, therefore changes within a single frame and never shows a half-updated filter.

The core always has priority on the shared single-port RAM. The unit writes only in cycles where the core does not claim the RAM, so the two never drive the RAM in the same cycle. Only entries the host touched since the previous transfer are committed. While a request is pending or a transfer is running, the unit reports busy and drops host staging writes and further commits. Bulk loads that halt the core are handled outside this block.

Top module: `safeload_xfer`

## Requirements
- R1: After reset, `busy` is 0, `stg_ready` is 1 and no staging entry is pending.
- R2: A staging write with `stg_sel` = k (0..4) loads the data word of entry k. A write with `stg_sel` = 5+k loads the target of entry k from the low 10 bits of `stg_wdata` and ignores the upper bits. Either write marks entry k pending.
- R3: A `commit_req` pulse while idle makes `busy` 1 from the following cycle. RAM is not written until a `frame_tick` pulse arrives in a later cycle.
- R4: Once a frame has started the transfer, each cycle with `core_ram_en` low writes the lowest-numbered pending entry's data word to its target address and clears that entry's pending mark.
- R5: In any cycle with `core_ram_en` high, the core alone accesses the RAM and the transfer waits. `busy` stays 1 until the core frees the RAM and the remaining entries are written.
- R6: An entry not written since the previous transfer is not written again, even when it still holds a valid address and data word.
- R7: `busy` stays 1 until every pending entry has been written, then returns to 0. `stg_ready` is its inverse.
- R8: Staging writes and commit pulses that arrive while `busy` is 1 have no effect on any entry's data, target or pending mark.
- R9: When two pending entries share a target, the higher-numbered entry is written last, so its data word remains in RAM.
- R10: With `core_ram_en` high, `core_we` 1 writes `core_wdata` to `core_addr`. With `core_we` 0, `core_rdata` shows the word at `core_addr` one cycle later.
- R11: A commit with no pending entries raises `busy`, waits for the frame, then returns to idle without changing RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stg_we | input | 1 | Staging register write strobe |
| stg_sel | input | 4 | Staging select: 0..4 data words, 5..9 targets |
| stg_wdata | input | 28 | Staging write value |
| stg_ready | output | 1 | High when staging writes are accepted |
| commit_req | input | 1 | Request a transfer of pending entries |
| frame_tick | input | 1 | One-cycle audio frame boundary pulse |
| core_ram_en | input | 1 | Core claims the parameter RAM this cycle |
| core_we | input | 1 | Core write (1) or read (0) |
| core_addr | input | 10 | Core RAM address |
| core_wdata | input | 28 | Core write data |
| core_rdata | output | 28 | Registered RAM read data |
| busy | output | 1 | Request pending or transfer in progress |

## Verification
The hardest state to reach from the ports is a transfer that the frame has already started but that the core has stalled. The stimulus creates it by holding `core_ram_en` high as a long read of the target address, starting in the same cycle the frame pulse is released. That read must return the old word, and `busy` must still be 1 when the core lets go. A second hard case is a staging write that arrives during busy and is dropped. That write is invisible until a later transfer. The bench exposes it by touching only the same entry's target after the unit goes idle, so the entry is committed again and must carry the data word from before the dropped write.

// File: rtl/safeload_pkg.sv
package safeload_pkg;
  localparam int unsigned SL_DATA_W  = 28;
  localparam int unsigned SL_ADDR_W  = 10;
  localparam int unsigned SL_ENTRIES = 5;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ARMED = 2'd1,
    SQ_MOVE  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/sl_stage.sv
module sl_stage #(
  parameter int DW    = 28,
  parameter int AW    = 10,
  parameter int SLOTS = 5,
  parameter int SW    = 4,
  parameter int IW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic             clr_en,
  input  logic [IW-1:0]    clr_idx,
  output logic [SLOTS-1:0] valid,
  output logic             any_valid,
  output logic [IW-1:0]    pick_idx,
  output logic [AW-1:0]    pick_addr,
  output logic [DW-1:0]    pick_data
);
  logic [DW-1:0]    data_q [SLOTS];
  logic [AW-1:0]    addr_q [SLOTS];
  logic [SLOTS-1:0] valid_q;

  for (genvar k = 0; k < SLOTS; k++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        data_q[k]  <= '0;
        addr_q[k]  <= '0;
        valid_q[k] <= 1'b0;
      end else if (wr_en && wr_sel == SW'(k)) begin
        data_q[k]  <= wr_data;
        valid_q[k] <= 1'b1;
      end else if (wr_en && wr_sel == SW'(SLOTS + k)) begin
        addr_q[k]  <= wr_data[AW-1:0];
        valid_q[k] <= 1'b1;
      end else if (clr_en && clr_idx == IW'(k)) begin
        valid_q[k] <= 1'b0;
      end
    end
  end

  // lowest-numbered pending entry goes first
  always_comb begin
    pick_idx  = '0;
    pick_addr = '0;
    pick_data = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (valid_q[i]) begin
        pick_idx  = IW'(i);
        pick_addr = addr_q[i];
        pick_data = data_q[i];
      end
    end
  end

  assign valid     = valid_q;
  assign any_valid = |valid_q;

  // R6: only a pending entry can be retired
  assert_clear_pending_R6: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> valid_q[clr_idx]);

  // R6: a retired entry stays retired unless the host touches it again
  assert_retired_stays_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(clr_en) && !$past(wr_en)) |-> !valid_q[$past(clr_idx)]);
endmodule

// File: rtl/sl_sequencer.sv
module sl_sequencer
  import safeload_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic commit,
  input  logic frame,
  input  logic core_claim,
  input  logic any_valid,
  output logic busy,
  output logic moving,
  output logic slot_go
);
  sq_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
    end else begin
      unique case (state_q)
        SQ_IDLE:  if (commit)     state_q <= SQ_ARMED;
        SQ_ARMED: if (frame)      state_q <= SQ_MOVE;
        SQ_MOVE:  if (!any_valid) state_q <= SQ_IDLE;
        default:                  state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy    = (state_q != SQ_IDLE);
  assign moving  = (state_q == SQ_MOVE);
  assign slot_go = moving && any_valid && !core_claim;

  // R3: a transfer starts only on a frame pulse
  assert_start_on_frame_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(moving) |-> $past(frame));

  // R7: the unit goes idle only after all pending entries are written
  assert_idle_when_drained_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !$past(any_valid));
endmodule

// File: rtl/sl_param_ram.sv
module sl_param_ram #(
  parameter int DW = 28,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/safeload_xfer.sv
module safeload_xfer
  import safeload_pkg::*;
#(
  parameter  int DW    = SL_DATA_W,
  parameter  int AW    = SL_ADDR_W,
  parameter  int SLOTS = SL_ENTRIES,
  localparam int SW    = $clog2(2 * SLOTS),
  localparam int IW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stg_we,
  input  logic [SW-1:0] stg_sel,
  input  logic [DW-1:0] stg_wdata,
  output logic          stg_ready,
  input  logic          commit_req,
  input  logic          frame_tick,
  input  logic          core_ram_en,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic [DW-1:0] core_rdata,
  output logic          busy
);
  logic             busy_w, moving, slot_go, any_valid;
  logic [SLOTS-1:0] valid;
  logic [IW-1:0]    pick_idx;
  logic [AW-1:0]    pick_addr;
  logic [DW-1:0]    pick_data;
  logic             ram_en, ram_we;
  logic [AW-1:0]    ram_addr;
  logic [DW-1:0]    ram_wdata;

  sl_stage #(.DW(DW), .AW(AW), .SLOTS(SLOTS), .SW(SW), .IW(IW)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (stg_we && !busy_w),
    .wr_sel    (stg_sel),
    .wr_data   (stg_wdata),
    .clr_en    (slot_go),
    .clr_idx   (pick_idx),
    .valid     (valid),
    .any_valid (any_valid),
    .pick_idx  (pick_idx),
    .pick_addr (pick_addr),
    .pick_data (pick_data)
  );

  sl_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .commit     (commit_req),
    .frame      (frame_tick),
    .core_claim (core_ram_en),
    .any_valid  (any_valid),
    .busy       (busy_w),
    .moving     (moving),
    .slot_go    (slot_go)
  );

  // core owns the port whenever it asks; safeload fills the gaps
  always_comb begin
    if (core_ram_en) begin
      ram_en    = 1'b1;
      ram_we    = core_we;
      ram_addr  = core_addr;
      ram_wdata = core_wdata;
    end else begin
      ram_en    = slot_go;
      ram_we    = slot_go;
      ram_addr  = pick_addr;
      ram_wdata = pick_data;
    end
  end

  sl_param_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (core_rdata)
  );

  assign busy      = busy_w;
  assign stg_ready = !busy_w;

  // R5: the transfer never takes a cycle that the core has claimed
  assert_no_contention_R5: assert property (@(posedge clk) disable iff (rst)
    core_ram_en |-> !slot_go);

  // R4: entries are retired only during a frame-started transfer
  assert_write_in_move_R4: assert property (@(posedge clk) disable iff (rst)
    slot_go |-> moving);

  // R8: host staging writes during busy leave the entries untouched
  assert_hold_off_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_w && stg_we && !slot_go) |=> $stable(valid));
endmodule

// File: tb/safeload_xfer_test.sv
module safeload_xfer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stg_we = 1'b0;
  logic [3:0]  stg_sel = '0;
  logic [27:0] stg_wdata = '0;
  logic        stg_ready;
  logic        commit_req = 1'b0;
  logic        frame_tick = 1'b0;
  logic        core_ram_en = 1'b0;
  logic        core_we = 1'b0;
  logic [9:0]  core_addr = '0;
  logic [27:0] core_wdata = '0;
  logic [27:0] core_rdata;
  logic        busy;

  int n_tests = 0;
  int n_fail  = 0;
  logic rd_req = 1'b0;
  logic rd_pend = 1'b0;
  logic [27:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  safeload_xfer uut (
    .clk(clk), .rst(rst), .stg_we(stg_we), .stg_sel(stg_sel),
    .stg_wdata(stg_wdata), .stg_ready(stg_ready), .commit_req(commit_req),
    .frame_tick(frame_tick), .core_ram_en(core_ram_en), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .busy(busy)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare each registered read against the scoreboard
  always @(posedge clk) rd_pend <= rd_req;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [27:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(core_rdata == e, t, {4'h0, core_rdata}, {4'h0, e});
    end
  end

  task automatic stage(input int sel, input logic [27:0] v);
    stg_we = 1'b1; stg_sel = 4'(sel); stg_wdata = v;
    @(negedge clk);
    stg_we = 1'b0;
  endtask

  task automatic commit();
    commit_req = 1'b1;
    @(negedge clk);
    commit_req = 1'b0;
  endtask

  task automatic frame();
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic core_wr(input logic [9:0] a, input logic [27:0] d);
    core_ram_en = 1'b1; core_we = 1'b1; core_addr = a; core_wdata = d;
    @(negedge clk);
    core_ram_en = 1'b0; core_we = 1'b0;
  endtask

  // holds the RAM for n cycles; the last one is the checked read
  task automatic read_ram(input logic [9:0] a, input logic [27:0] e,
                          input string tag, input int n);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    core_ram_en = 1'b1; core_we = 1'b0; core_addr = a;
    repeat (n - 1) @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; core_ram_en = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);
    check(!busy, tag, {31'd0, busy}, 32'd0);
  endtask

  function automatic logic [27:0] dval(input int k);
    return 28'h1000000 + 28'(k) * 28'h0011111;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", {31'd0, busy}, 32'd0);
    check(stg_ready == 1'b1, "R1 ready", {31'd0, stg_ready}, 32'd1);

    // full five-entry set; R2 map, R3 wait for frame, R4 order, R7 busy
    core_wr(10'h100, 28'h0ABCDEF);
    for (int k = 0; k < 5; k++) begin
      stage(k, dval(k));
      stage(5 + k, 28'(10'h100 + 10'(k)));
    end
    commit();
    check(busy == 1'b1, "R3 busy after commit", {31'd0, busy}, 32'd1);
    repeat (4) @(negedge clk);
    read_ram(10'h100, 28'h0ABCDEF, "R3 no write before frame", 1);
    check(busy == 1'b1, "R3 still armed", {31'd0, busy}, 32'd1);
    frame();
    repeat (2) @(negedge clk);
    check(busy == 1'b1, "R7 busy mid transfer", {31'd0, busy}, 32'd1);
    check(stg_ready == 1'b0, "R7 ready low", {31'd0, stg_ready}, 32'd0);
    wait_idle("R7 idle after drain");
    for (int k = 0; k < 5; k++)
      read_ram(10'h100 + 10'(k), dval(k), "R4 committed word", 1);

    // R5 core stalls the transfer
    core_wr(10'h120, 28'h0000055);
    stage(0, 28'h0E0E0E0);
    stage(5, 28'h120);
    commit();
    frame();
    read_ram(10'h120, 28'h0000055, "R5 old word while core holds RAM", 12);
    check(busy == 1'b1, "R5 busy while stalled", {31'd0, busy}, 32'd1);
    wait_idle("R5 idle after release");
    read_ram(10'h120, 28'h0E0E0E0, "R5 word after release", 1);

    // R6 only touched entries are committed
    core_wr(10'h100, 28'h0001234);
    stage(2, 28'h0F2F2F2);
    commit();
    frame();
    wait_idle("R6 idle");
    read_ram(10'h100, 28'h0001234, "R6 untouched entry not rewritten", 1);
    read_ram(10'h102, 28'h0F2F2F2, "R6 touched entry", 1);

    // R8 hold-off during busy
    stage(0, 28'h0111111);
    stage(5, 28'h150);
    commit();
    check(stg_ready == 1'b0, "R8 ready low while armed", {31'd0, stg_ready}, 32'd0);
    stage(0, 28'h0222222);
    stage(5, 28'h160);
    frame();
    wait_idle("R8 idle");
    read_ram(10'h150, 28'h0111111, "R8 dropped write during busy", 1);
    stage(5, 28'h151);
    commit();
    frame();
    wait_idle("R8 idle 2");
    read_ram(10'h151, 28'h0111111, "R8 data word kept", 1);

    // R9 duplicate targets, R2 upper target bits ignored
    core_wr(10'h123, 28'h0);
    stage(0, 28'h0AAAAAA);
    stage(5, 28'hABCD123);
    stage(4, 28'h0444444);
    stage(9, 28'h0000123);
    stage(3, 28'h0333333);
    stage(8, 28'h0000133);
    commit();
    frame();
    wait_idle("R9 idle");
    read_ram(10'h123, 28'h0444444, "R9 last entry wins", 1);
    read_ram(10'h133, 28'h0333333, "R2 entry 3 target", 1);

    // R11 empty commit
    commit();
    check(busy == 1'b1, "R11 busy on empty commit", {31'd0, busy}, 32'd1);
    frame();
    wait_idle("R11 idle");
    read_ram(10'h123, 28'h0444444, "R11 RAM unchanged", 1);

    // R10 direct core port
    core_wr(10'h3FF, 28'hFEDCBA9);
    read_ram(10'h3FF, 28'hFEDCBA9, "R10 core read back", 1);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule